// File: doc/BRIEF.md
# Processor Boot-Fetch Watch

This block decides whether the processor came alive after reset. Once the processor is released from reset, the block opens a detection window of programmable length. It then waits for a strobe that marks the processor's first instruction fetch. If the strobe arrives inside the window, the monitor settles into a passed state and stays silent. If it does not arrive, the monitor declares a processor failure and raises a status flag. It then carries out the alert actions that were configured.

The alert actions are three. The first drives a general-purpose output with one fixed-width pulse. The second drives that same output as a blinking LED pattern. The third raises a request toward an external SMBus controller, which can have a network controller send a distress notice. The request is a level held until an acknowledge comes back. The message itself and the bus transfer belong to the neighbouring controller.

The configuration is sampled once, on the clock edge that sees the release. Both outcomes, passed and failed, hold until the next synchronous system reset.

Top module: `cpu_boot_watch`

## Requirements
- R1: After reset, `fail_flag`, `alert_pin` and `msg_req` are 0. While `cpu_release` stays low, no failure is ever declared, however long the wait.
- R2: Let L be the value of `cfg_limit` captured on the edge that samples `cpu_release` high. If `fetch_stb` is sampled high on any of the L+1 following edges, the monitor passes and `fail_flag` never rises. This includes the case where the strobe lands on the last edge of the window.
- R3: If `fetch_stb` is not sampled high on any of those L+1 edges, `fail_flag` is 0 after the L-th edge and 1 after edge L+1.
- R4: Every configuration input (`cfg_limit`, `cfg_pulse_en`, `cfg_blink_en`, `cfg_msg_en`) is captured on the release edge. Later changes have no effect on the window or on the alerts.
- R5: Passed and failed are both sticky until `rst`. Once either is reached, further `cpu_release` or `fetch_stb` activity changes nothing, and `rst` returns `fail_flag` to 0.
- R6: With pulse enabled and blink disabled, `alert_pin` rises on the failure edge and stays high for exactly PULSE_W cycles, then stays low.
- R7: With pulse and blink both enabled, `alert_pin` rises on the failure edge. It is then high for BLINK_HALF cycles and low for BLINK_HALF cycles, repeating for as long as the failure lasts.
- R8: With pulse disabled, `alert_pin` stays 0 whatever the blink setting.
- R9: With message enabled, `msg_req` rises on the same edge as `fail_flag` and holds until `msg_ack` is sampled high. It falls on that edge and is never raised again before `rst`.
- R10: With message disabled, `msg_req` never rises. An `msg_ack` that arrives while no request is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| cpu_release | input | 1 | High when the processor is let out of reset; starts the window |
| fetch_stb | input | 1 | Strobe marking the processor's first instruction fetch |
| cfg_pulse_en | input | 1 | Enables driving of the alert output on failure |
| cfg_blink_en | input | 1 | Selects the blink pattern instead of a single pulse |
| cfg_msg_en | input | 1 | Enables the distress-message request |
| cfg_limit | input | 16 | Window length: the window lasts this value plus one cycles |
| msg_ack | input | 1 | Acknowledge from the SMBus controller |
| alert_pin | output | 1 | GPIO / LED drive |
| msg_req | output | 1 | Distress-message request, held until acknowledged |
| fail_flag | output | 1 | Sticky processor-failure status |

## Verification
The window is swept over limits 0 to 5. For each limit, the fetch strobe is placed at every offset from the first edge of the window to two edges past its end. This separates an off-by-one error at either end of the window and shows which input wins when the strobe meets the last window edge. Runs with no strobe at all pin the exact edge on which the failure flag rises.

All eight combinations of the pulse, blink and message enables are then driven through a failure. The alert output is compared cycle by cycle against the pulse-width or half-period formula. This tells a pulse apart from a blink and catches an enable that leaks into the wrong mode. Further runs cover an acknowledge that arrives early or late, configuration changes made after the release edge, and repeated release or fetch activity once the outcome is settled. These show that the captured setup and the outcome do not move.

// File: rtl/cpu_boot_watch_pkg.sv
package cpu_boot_watch_pkg;

    localparam int LIM_W = 16;

    typedef enum logic [1:0] {
        MON_IDLE   = 2'd0,
        MON_WAIT   = 2'd1,
        MON_PASSED = 2'd2,
        MON_FAILED = 2'd3
    } mon_state_e;

    typedef struct packed {
        logic [LIM_W-1:0] limit;
        logic             pulse_en;
        logic             blink_en;
        logic             msg_en;
    } mon_cfg_t;

    // True on the last cycle of the detection window.
    function automatic logic window_end(input logic [LIM_W-1:0] cnt,
                                        input logic [LIM_W-1:0] lim);
        return cnt == lim;
    endfunction

endpackage

// File: rtl/cbw_window.sv
module cbw_window
    import cpu_boot_watch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_release,
    input  logic       fetch_stb,
    input  mon_cfg_t   cfg_in,
    output mon_state_e state,
    output mon_cfg_t   cfg_q,
    output logic       fail_ev
);

    logic [LIM_W-1:0] cnt;

    assign fail_ev = (state == MON_WAIT) && !fetch_stb && window_end(cnt, cfg_q.limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MON_IDLE;
            cnt   <= '0;
            cfg_q <= '0;
        end else begin
            case (state)
                MON_IDLE: begin
                    if (cpu_release) begin
                        state <= MON_WAIT;
                        cnt   <= '0;
                        cfg_q <= cfg_in;
                    end
                end
                MON_WAIT: begin
                    if (fetch_stb)
                        state <= MON_PASSED;
                    else if (fail_ev)
                        state <= MON_FAILED;
                    else
                        cnt <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    p_fail_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (state == MON_FAILED) |=> (state == MON_FAILED));

    p_pass_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (state == MON_PASSED) |=> (state == MON_PASSED));

    p_no_early_fail_r3: assert property (@(posedge clk) disable iff (rst)
        (state == MON_WAIT && cnt != cfg_q.limit) |=> (state != MON_FAILED));

    p_fetch_wins_r2: assert property (@(posedge clk) disable iff (rst)
        (state == MON_WAIT && fetch_stb) |=> (state == MON_PASSED));

    p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (state != MON_IDLE) |=> $stable(cfg_q));

endmodule

// File: rtl/cbw_alert_pin.sv
module cbw_alert_pin #(
    parameter int PULSE_W    = 8,
    parameter int BLINK_HALF = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fail_ev,
    input  logic pulse_en,
    input  logic blink_en,
    output logic pin
);

    localparam int SPAN = (PULSE_W > BLINK_HALF) ? PULSE_W : BLINK_HALF;
    localparam int CW   = $clog2(SPAN + 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_W - 1);
    localparam logic [CW-1:0] HALF_LAST  = CW'(BLINK_HALF - 1);

    logic [CW-1:0] pcnt;
    logic          active;
    logic          blink_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin        <= 1'b0;
            pcnt       <= '0;
            active     <= 1'b0;
            blink_mode <= 1'b0;
        end else if (fail_ev && pulse_en) begin
            pin        <= 1'b1;
            pcnt       <= '0;
            active     <= 1'b1;
            blink_mode <= blink_en;
        end else if (active) begin
            if (blink_mode) begin
                if (pcnt == HALF_LAST) begin
                    pin  <= ~pin;
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end else begin
                if (pcnt == PULSE_LAST) begin
                    pin    <= 1'b0;
                    active <= 1'b0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end
        end
    end

    p_pin_off_r8: assert property (@(posedge clk) disable iff (rst)
        (!pulse_en) |-> (!pin));

    p_pin_starts_on_fail_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pin) |-> ($past(fail_ev) || $past(blink_mode)));

    p_pulse_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (!active && !fail_ev) |=> !pin);

endmodule

// File: rtl/cbw_msg_req.sv
module cbw_msg_req (
    input  logic clk,
    input  logic rst,
    input  logic fail_ev,
    input  logic msg_en,
    input  logic msg_ack,
    output logic req
);

    always_ff @(posedge clk) begin
        if (rst)
            req <= 1'b0;
        else if (fail_ev && msg_en)
            req <= 1'b1;
        else if (req && msg_ack)
            req <= 1'b0;
    end

    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (req && !msg_ack) |=> req);

    p_req_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (req && msg_ack) |=> !req);

    p_req_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> ($past(fail_ev) && $past(msg_en)));

endmodule

// File: rtl/cpu_boot_watch.sv
module cpu_boot_watch
    import cpu_boot_watch_pkg::*;
#(
    parameter int PULSE_W    = 8,
    parameter int BLINK_HALF = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_release,
    input  logic             fetch_stb,
    input  logic             cfg_pulse_en,
    input  logic             cfg_blink_en,
    input  logic             cfg_msg_en,
    input  logic [LIM_W-1:0] cfg_limit,
    input  logic             msg_ack,
    output logic             alert_pin,
    output logic             msg_req,
    output logic             fail_flag
);

    mon_cfg_t   cfg_in;
    mon_cfg_t   cfg_q;
    mon_state_e state;
    logic       fail_ev;

    always_comb begin
        cfg_in.limit    = cfg_limit;
        cfg_in.pulse_en = cfg_pulse_en;
        cfg_in.blink_en = cfg_blink_en;
        cfg_in.msg_en   = cfg_msg_en;
    end

    cbw_window u_window (
        .clk         (clk),
        .rst         (rst),
        .cpu_release (cpu_release),
        .fetch_stb   (fetch_stb),
        .cfg_in      (cfg_in),
        .state       (state),
        .cfg_q       (cfg_q),
        .fail_ev     (fail_ev)
    );

    cbw_alert_pin #(
        .PULSE_W    (PULSE_W),
        .BLINK_HALF (BLINK_HALF)
    ) u_pin (
        .clk      (clk),
        .rst      (rst),
        .fail_ev  (fail_ev),
        .pulse_en (cfg_q.pulse_en),
        .blink_en (cfg_q.blink_en),
        .pin      (alert_pin)
    );

    cbw_msg_req u_msg (
        .clk     (clk),
        .rst     (rst),
        .fail_ev (fail_ev),
        .msg_en  (cfg_q.msg_en),
        .msg_ack (msg_ack),
        .req     (msg_req)
    );

    assign fail_flag = (state == MON_FAILED);

    p_req_with_fail_r9: assert property (@(posedge clk) disable iff (rst)
        msg_req |-> fail_flag);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state == MON_IDLE) |-> (!fail_flag && !alert_pin && !msg_req));

endmodule

// File: tb/test_cpu_boot_watch.sv
module test_cpu_boot_watch;

    localparam int PW = 3;
    localparam int HB = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_release = 1'b0;
    logic        fetch_stb = 1'b0;
    logic        cfg_pulse_en = 1'b0;
    logic        cfg_blink_en = 1'b0;
    logic        cfg_msg_en = 1'b0;
    logic [15:0] cfg_limit = '0;
    logic        msg_ack = 1'b0;
    logic        alert_pin;
    logic        msg_req;
    logic        fail_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cpu_boot_watch #(.PULSE_W(PW), .BLINK_HALF(HB)) i_cpu_boot_watch (
        .clk(clk), .rst(rst), .cpu_release(cpu_release), .fetch_stb(fetch_stb),
        .cfg_pulse_en(cfg_pulse_en), .cfg_blink_en(cfg_blink_en),
        .cfg_msg_en(cfg_msg_en), .cfg_limit(cfg_limit), .msg_ack(msg_ack),
        .alert_pin(alert_pin), .msg_req(msg_req), .fail_flag(fail_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cpu_release = 0; fetch_stb = 0; msg_ack = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Returns at the negedge following the release edge.
    task automatic release_cpu(input int lim, input bit pe, input bit be, input bit me);
        cfg_limit = 16'(lim); cfg_pulse_en = pe; cfg_blink_en = be; cfg_msg_en = me;
        cpu_release = 1'b1;
        @(negedge clk);
        cpu_release = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state and idle without release
        do_reset();
        check("R1 fail_flag reset", int'(fail_flag), 0);
        check("R1 alert_pin reset", int'(alert_pin), 0);
        check("R1 msg_req reset", int'(msg_req), 0);
        cfg_limit = 16'd0; cfg_pulse_en = 1; cfg_msg_en = 1;
        repeat (40) @(negedge clk);
        check("R1 no fail while held", int'(fail_flag), 0);
        check("R1 no req while held", int'(msg_req), 0);

        // R2/R3: sweep limit and strobe offset
        for (int lim = 0; lim <= 5; lim++) begin
            for (int j = 0; j <= lim + 2; j++) begin
                do_reset();
                @(negedge clk);
                release_cpu(lim, 1'b1, 1'b0, 1'b1);
                repeat (j) @(negedge clk);
                fetch_stb = 1'b1;
                @(negedge clk);
                fetch_stb = 1'b0;
                repeat (lim + 4) @(negedge clk);
                if (j <= lim)
                    check("R2 fetch inside window passes", int'(fail_flag), 0);
                else
                    check("R3 fetch after window fails", int'(fail_flag), 1);
            end
            // exact failure edge, no strobe at all
            do_reset();
            @(negedge clk);
            release_cpu(lim, 1'b0, 1'b0, 1'b0);
            repeat (lim) @(negedge clk);
            check("R3 flag low after edge L", int'(fail_flag), 0);
            @(negedge clk);
            check("R3 flag high after edge L+1", int'(fail_flag), 1);
        end

        // R6/R7/R8/R9/R10: all enable combinations
        for (int c = 0; c < 8; c++) begin
            bit pe, be, me;
            pe = c[0]; be = c[1]; me = c[2];
            do_reset();
            @(negedge clk);
            release_cpu(2, pe, be, me);
            repeat (2) @(negedge clk);
            @(negedge clk);
            check("R3 fail in combo", int'(fail_flag), 1);
            check(me ? "R9 req with fail" : "R10 no req when disabled", int'(msg_req), int'(me));
            for (int i = 0; i < 12; i++) begin
                int exp;
                if (!pe) exp = 0;
                else if (be) exp = (((i / HB) % 2) == 0) ? 1 : 0;
                else exp = (i < PW) ? 1 : 0;
                if (!pe) check("R8 pin stays low", int'(alert_pin), exp);
                else if (be) check("R7 blink pattern", int'(alert_pin), exp);
                else check("R6 single pulse", int'(alert_pin), exp);
                @(negedge clk);
            end
            check(me ? "R9 req held w/o ack" : "R10 still no req", int'(msg_req), int'(me));
        end

        // R9/R10: early ack ignored, late ack drops, no reissue
        do_reset();
        @(negedge clk);
        release_cpu(3, 1'b0, 1'b0, 1'b1);
        msg_ack = 1'b1;
        @(negedge clk);
        msg_ack = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 early ack ignored", int'(msg_req), 1);
        repeat (5) @(negedge clk);
        check("R9 req holds", int'(msg_req), 1);
        msg_ack = 1'b1;
        @(negedge clk);
        msg_ack = 1'b0;
        check("R9 req drops after ack", int'(msg_req), 0);
        cpu_release = 1'b1;
        repeat (10) @(negedge clk);
        cpu_release = 1'b0;
        check("R9 req not reissued", int'(msg_req), 0);
        check("R5 fail stays after release", int'(fail_flag), 1);
        fetch_stb = 1'b1;
        @(negedge clk);
        fetch_stb = 1'b0;
        check("R5 fail stays after fetch", int'(fail_flag), 1);
        do_reset();
        check("R5 reset clears fail", int'(fail_flag), 0);

        // R4: config changed after release is ignored
        @(negedge clk);
        release_cpu(1, 1'b1, 1'b0, 1'b0);
        cfg_limit = 16'd20; cfg_blink_en = 1; cfg_msg_en = 1; cfg_pulse_en = 0;
        @(negedge clk);
        check("R4 pre-edge still waiting", int'(fail_flag), 0);
        @(negedge clk);
        check("R4 captured limit used", int'(fail_flag), 1);
        check("R4 captured msg disable", int'(msg_req), 0);
        check("R4 captured pulse enable", int'(alert_pin), 1);
        repeat (PW) @(negedge clk);
        check("R4 captured pulse mode", int'(alert_pin), 0);

        // R5: passed is sticky
        do_reset();
        @(negedge clk);
        release_cpu(2, 1'b1, 1'b0, 1'b1);
        fetch_stb = 1'b1;
        @(negedge clk);
        fetch_stb = 1'b0;
        cpu_release = 1'b1;
        @(negedge clk);
        cpu_release = 1'b0;
        repeat (20) @(negedge clk);
        check("R5 pass sticky flag", int'(fail_flag), 0);
        check("R5 pass sticky pin", int'(alert_pin), 0);
        check("R5 pass sticky req", int'(msg_req), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule